// File: doc/BRIEF.md
# Prioritised Interrupt Status Aggregator

This block gathers level interrupt requests from thirteen peripheral sources and records them in a 32-bit pending register. Each source has a fixed bit in that register, and the bits are not contiguous. Each source also belongs to one of three CPU priority groups: 3, 5 or 6. A 32-bit enable register gates which pending bits may reach the processor. The block drives a 3-bit priority level: the highest group that has an enabled pending bit, or zero when none is pending.

The pending register follows the edges of the sources. A rising request sets its bit, and a falling request clears it. A source that stays at one level leaves its bit alone, so software may clear or set bits through the register port between edges. A write to the storage controller's control register also reaches this block: its DMA-enable field forces the storage-DMA pending bit to follow it.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, the pending register reads 0, the enable register reads 0 and the priority output is 0.
- R2: Request index i (0..12) maps to pending bit 7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21 in index order. A rising request sets its bit at the clock edge that first samples it high.
- R3: A falling request clears its pending bit at the clock edge that first samples it low.
- R4: A request that holds its level does not change its pending bit, so a bit cleared by software stays clear while its request stays high.
- R5: A register write at offset 0x7000 replaces the pending register and one at offset 0x7800 replaces the enable register. The read data shows the register at the presented offset. Writes to any other offset change nothing, and reads of any other offset return 0.
- R6: A pending bit counts toward the priority output only when the enable bit at the same position is 1.
- R7: Indices 0..6 (bits 7, 3, 2, 9, 10, 12, 5) form group 3, index 7 (bit 17) forms group 5, and indices 8..12 (bits 28, 27, 26, 23, 21) form group 6. The output is 6 if any enabled group-6 bit is pending, else 5 for group 5, else 3 for group 3, else 0.
- R8: A storage-control write forces pending bit 26 to the value of its DMA-enable input.
- R9: When a request edge and a CPU write to the pending register fall in the same cycle, the edge decides the source's bit. The CPU write still decides every other bit.
- R10: A request edge on index 10 overrides a storage-control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 13 | Level interrupt requests, indices 0..12 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| scsi_ctl_wr | input | 1 | Storage-control write strobe |
| scsi_ctl_dma_en | input | 1 | DMA-enable field of that write |
| cpu_ipl | output | 3 | Priority level presented to the CPU |

## Verification
Three updates can land on one pending bit in the same cycle: a source edge, a CPU write to the pending register, and a storage-control force. The bench lines up a rising and a falling request in the very cycle in which a register write asserts the opposite value for that bit. It then reads the register back and expects the edge to win, while the rest of the written word still takes effect. A second case raises request 10 together with a storage-control write that drives bit 26 low, and expects the bit to read high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 13;

    typedef enum logic [2:0] {
        IPL_NONE = 3'd0,
        IPL_LOW  = 3'd3,
        IPL_MID  = 3'd5,
        IPL_HIGH = 3'd6
    } ipl_e;

    typedef struct packed {
        logic [DATA_W-1:0] set;
        logic [DATA_W-1:0] clr;
    } hw_upd_t;

    // Fixed status bit for each request index
    function automatic int src_bit(input int idx);
        case (idx)
            0:  return 7;
            1:  return 3;
            2:  return 2;
            3:  return 9;
            4:  return 10;
            5:  return 12;
            6:  return 5;
            7:  return 17;
            8:  return 28;
            9:  return 27;
            10: return 26;
            11: return 23;
            default: return 21;
        endcase
    endfunction

    // Priority group of each request index
    function automatic ipl_e src_group(input int idx);
        if (idx <= 6)      return IPL_LOW;
        else if (idx == 7) return IPL_MID;
        else               return IPL_HIGH;
    endfunction

    // Status bits belonging to one group
    function automatic logic [DATA_W-1:0] group_mask(input ipl_e grp);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_group(i) == grp) m[src_bit(i)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    output hw_upd_t            upd
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise, fall;

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_req;
    end

    assign rise = src_req & ~src_q;
    assign fall = ~src_req & src_q;

    always_comb begin
        upd.set = '0;
        upd.clr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            upd.set[src_bit(i)] = rise[i];
            upd.clr[src_bit(i)] = fall[i];
        end
    end

    // A mapped bit is never set and cleared in the same cycle (R2, R3)
    assert_set_clr_disjoint_R3: assert property (@(posedge clk) disable iff (rst)
        (upd.set & upd.clr) == '0);

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int SCSI_DMA_BIT = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  hw_upd_t           upd,
    input  logic              wr_status,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ctl_wr,
    input  logic              ctl_dma_en,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] mask
);
    logic [DATA_W-1:0] st_sw, st_next;

    // Lowest precedence first: CPU write, then control force, then edges
    always_comb begin
        st_sw = wr_status ? wdata : status;
        if (ctl_wr) st_sw[SCSI_DMA_BIT] = ctl_dma_en;
        st_next = (st_sw | upd.set) & ~upd.clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= st_next;
            if (wr_mask) mask <= wdata;
        end
    end

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|upd.set) |=> ((status & $past(upd.set)) == $past(upd.set)));

    assert_edge_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (|upd.clr) |=> ((status & $past(upd.clr)) == '0));

    assert_mask_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask == $past(wdata)));

    assert_ctl_force_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !upd.set[SCSI_DMA_BIT] && !upd.clr[SCSI_DMA_BIT])
        |=> (status[SCSI_DMA_BIT] == $past(ctl_dma_en)));

    assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_status && !ctl_wr && upd.set == '0 && upd.clr == '0) |=> $stable(status));

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_agg_pkg::*;
(
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] mask,
    output ipl_e              level
);
    localparam logic [DATA_W-1:0] G_HIGH = group_mask(IPL_HIGH);
    localparam logic [DATA_W-1:0] G_MID  = group_mask(IPL_MID);
    localparam logic [DATA_W-1:0] G_LOW  = group_mask(IPL_LOW);

    logic [DATA_W-1:0] live;
    assign live = status & mask;

    always_comb begin
        if (|(live & G_HIGH))     level = IPL_HIGH;
        else if (|(live & G_MID)) level = IPL_MID;
        else if (|(live & G_LOW)) level = IPL_LOW;
        else                      level = IPL_NONE;
    end

    always_comb begin
        assert_masked_quiet_R6: assert ((live != '0) || (level == IPL_NONE));
        assert_legal_level_R7: assert (level inside {IPL_NONE, IPL_LOW, IPL_MID, IPL_HIGH});
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter logic [15:0] STATUS_OFS   = 16'h7000,
    parameter logic [15:0] MASK_OFS     = 16'h7800,
    parameter int          SCSI_DMA_BIT = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               scsi_ctl_wr,
    input  logic               scsi_ctl_dma_en,
    output logic [2:0]         cpu_ipl
);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] MK_A = ADDR_W'(MASK_OFS);

    hw_upd_t           upd;
    logic [DATA_W-1:0] status, mask;
    logic              hit_st, hit_mk;
    ipl_e              level;

    assign hit_st = (reg_addr == ST_A);
    assign hit_mk = (reg_addr == MK_A);

    irq_src_map u_map (
        .clk     (clk),
        .rst     (rst),
        .src_req (src_req),
        .upd     (upd)
    );

    irq_regs #(.SCSI_DMA_BIT(SCSI_DMA_BIT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .upd        (upd),
        .wr_status  (reg_wr && hit_st),
        .wr_mask    (reg_wr && hit_mk),
        .wdata      (reg_wdata),
        .ctl_wr     (scsi_ctl_wr),
        .ctl_dma_en (scsi_ctl_dma_en),
        .status     (status),
        .mask       (mask)
    );

    irq_level_enc u_enc (
        .status (status),
        .mask   (mask),
        .level  (level)
    );

    always_comb begin
        if (hit_st)      reg_rdata = status;
        else if (hit_mk) reg_rdata = mask;
        else             reg_rdata = '0;
    end

    assign cpu_ipl = level;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status == '0 && mask == '0 && cpu_ipl == 3'd0));

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] src_req;
    logic        reg_wr;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        scsi_ctl_wr;
    logic        scsi_ctl_dma_en;
    logic [2:0]  cpu_ipl;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [15:0] A_ST = 16'h7000;
    localparam logic [15:0] A_MK = 16'h7800;

    // {src[12:0], mask[31:0], exp_status[31:0], exp_ipl[2:0]}
    localparam int ROWS = 10;
    localparam logic [79:0] TBL [ROWS] = '{
        {13'h0001, 32'hFFFF_FFFF, 32'h0000_0080, 3'd3},
        {13'h0080, 32'hFFFF_FFFF, 32'h0002_0000, 3'd5},
        {13'h0400, 32'hFFFF_FFFF, 32'h0400_0000, 3'd6},
        {13'h0481, 32'hFFFF_FFFF, 32'h0402_0080, 3'd6},
        {13'h0481, 32'h0002_0080, 32'h0402_0080, 3'd5},
        {13'h0481, 32'h0000_0080, 32'h0402_0080, 3'd3},
        {13'h0481, 32'h0000_0000, 32'h0402_0080, 3'd0},
        {13'h0042, 32'hFFFF_FFD7, 32'h0000_0028, 3'd0},
        {13'h1B00, 32'h0020_0000, 32'h18A0_0000, 3'd6},
        {13'h003C, 32'h0000_1000, 32'h0000_1604, 3'd3}
    };

    irq_aggregator u_dut (
        .clk             (clk),
        .rst             (rst),
        .src_req         (src_req),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .scsi_ctl_wr     (scsi_ctl_wr),
        .scsi_ctl_dma_en (scsi_ctl_dma_en),
        .cpu_ipl         (cpu_ipl)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        reg_wr      = 1'b0;
        scsi_ctl_wr = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        rst = 1'b1; src_req = '0; reg_wr = 1'b0; reg_addr = A_ST; reg_wdata = '0;
        scsi_ctl_wr = 1'b0; scsi_ctl_dma_en = 1'b0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 status", A_ST, 32'h0);
        rd_chk("R1 mask", A_MK, 32'h0);
        chk("R1 ipl", {29'd0, cpu_ipl}, 32'd0);

        // Table walk: R2 mapping, R6 gating, R7 priority
        for (int r = 0; r < ROWS; r++) begin
            src_req = '0; tick();
            wr(A_ST, 32'h0);
            wr(A_MK, TBL[r][66:35]);
            src_req = TBL[r][79:67];
            tick();
            rd_chk($sformatf("R2 row %0d status", r), A_ST, TBL[r][34:3]);
            chk($sformatf("R7 R6 row %0d ipl", r), {29'd0, cpu_ipl}, {29'd0, TBL[r][2:0]});
        end

        // R3 falling edge clears
        src_req = '0; tick(); wr(A_ST, 32'h0);
        src_req = 13'h0001; tick();
        src_req = 13'h0000; tick();
        rd_chk("R3 fall clears bit 7", A_ST, 32'h0);

        // R4 steady level leaves software-cleared bit clear
        src_req = 13'h0001; tick();
        wr(A_ST, 32'h0);
        tick(); tick();
        rd_chk("R4 held request no re-set", A_ST, 32'h0);

        // R5 other offsets ignored and read zero
        wr(A_ST, 32'h1234_5678);
        wr(A_MK, 32'h0F0F_0000);
        wr(16'h7004, 32'hFFFF_FFFF);
        rd_chk("R5 status readback", A_ST, 32'h1234_5678);
        rd_chk("R5 mask readback", A_MK, 32'h0F0F_0000);
        rd_chk("R5 unmapped reads zero", 16'h7004, 32'h0);

        // R8 storage-control force of bit 26
        src_req = '0; tick(); wr(A_ST, 32'h0); wr(A_MK, 32'hFFFF_FFFF);
        scsi_ctl_wr = 1'b1; scsi_ctl_dma_en = 1'b1; tick();
        rd_chk("R8 force high", A_ST, 32'h0400_0000);
        chk("R8 ipl 6", {29'd0, cpu_ipl}, 32'd6);
        scsi_ctl_wr = 1'b1; scsi_ctl_dma_en = 1'b0; tick();
        rd_chk("R8 force low", A_ST, 32'h0);

        // R9 rising edge beats CPU write on same bit
        src_req = 13'h0001;
        wr(A_ST, 32'h0000_0001);
        rd_chk("R9 rise wins", A_ST, 32'h0000_0081);
        // R9 falling edge beats CPU write
        src_req = 13'h0000;
        wr(A_ST, 32'h0000_0080);
        rd_chk("R9 fall wins", A_ST, 32'h0);

        // R10 edge on index 10 beats control force low
        src_req = 13'h0400; scsi_ctl_wr = 1'b1; scsi_ctl_dma_en = 1'b0;
        tick();
        rd_chk("R10 edge over force", A_ST, 32'h0400_0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule